// File: doc/BRIEF.md
# Processor Reset and Startup Sequencer

This block stands between an asynchronous, active-high external reset pin and a 16-bit processor core. It brings the pin into the core clock domain, measures how long the pin stayed high, and keeps the core dormant for as long as reset is asserted. Once a reset of sufficient width is released, it runs a fixed-length internal startup count. When the count finishes, it lowers the core hold and gives a single-cycle fetch pulse together with the 20-bit power-on fetch address.

The block also supervises the non-maskable interrupt pin. The interrupt stays blocked through reset and for the first cycle after release. A rising interrupt edge that arrives while the interrupt is blocked is remembered and is delivered once, as soon as the interrupt becomes allowed.

A pulse that is too short to count as a reset is flagged and otherwise ignored. A core that was running resumes without a new fetch. A core that had not yet started stays held.

Top module: `boot_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns `core_hold`=1, and `fetch_start`, `nmi_allowed`, `nmi_pending`, `nmi_take` and `reset_too_short` all to 0. After `rst_n` rises, `core_hold` stays 1 until a valid reset pulse has been seen and released.
- R2: `reset_pin` passes through a two-stage synchronizer. `core_hold` is 1 after the third rising edge that follows the pin going high, and it stays 1 for as long as the pin is high.
- R3: A pulse counts as valid only when the synchronized reset is sampled high on at least 5 (MIN_HIGH+1) consecutive rising edges. A pulse of 4 or fewer edges does the following:
  - it sets `reset_too_short` on the edge that sees the release, and `reset_too_short` stays set until the next pulse begins;
  - it produces no `fetch_start`;
  - it returns `core_hold` and `nmi_allowed` to their values before the pulse (0 and 1 if the core was running, 1 and 0 otherwise).
- R4: After a valid pulse, `core_hold` falls and `fetch_start` is 1 for exactly one cycle after the 10th rising edge following the pin's fall. This is 2 synchronizer edges, plus the release edge, plus STARTUP_CYCLES=7. `fetch_start` is never 1 while `core_hold` is 1.
- R5: `reset_vector` always reads 20'hFFFF0.
- R6: A new pulse that starts during the startup count aborts the count. If that new pulse proves too short, the core stays held and no fetch occurs until a later valid pulse completes.
- R7: `nmi_allowed` goes low when a rising reset is synchronized. After a valid pulse, it goes high after the 4th rising edge following the pin's fall (the second cycle after release), and it stays high until the next pulse.
- R8: A rising edge on `nmi_pin` while `nmi_allowed` is 1 gives a one-cycle `nmi_take` after the third rising edge following the pin edge. A pin that is held high does not fire again.
- R9: A rising `nmi_pin` edge while `nmi_allowed` is 0 sets `nmi_pending` and gives no `nmi_take`. On the first edge at which `nmi_allowed` is 1, `nmi_take` pulses once and `nmi_pending` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low power-on reset of the sequencer itself |
| reset_pin | input | 1 | Asynchronous active-high external reset request |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt request, rising-edge sensitive |
| core_hold | output | 1 | 1 keeps the core dormant |
| fetch_start | output | 1 | One-cycle pulse: begin fetching at `reset_vector` |
| reset_vector | output | 20 | Power-on fetch address, 20'hFFFF0 |
| nmi_allowed | output | 1 | Interrupt recognition window is open |
| nmi_pending | output | 1 | An early interrupt edge is waiting for the window |
| nmi_take | output | 1 | One-cycle interrupt delivery to the core |
| reset_too_short | output | 1 | Last reset pulse was below the minimum width and was ignored |

## Verification
Reset pulses are tried at widths around the 4/5-edge threshold, starting from both a held core and a running core. This separates an ignored pulse that restores running from one that leaves the core held. Seeded random widths and gaps check the release-to-fetch distance against a timeline computed in the bench. A pulse that starts inside the startup count shows that the count is aborted and not resumed. Interrupt edges are placed inside the blocked window and after it, which separates deferred delivery from direct delivery and from level retriggering.

// File: rtl/boot_seq_pkg.sv
// Shared types for the reset and startup sequencer.
// Assumes: no external dependencies.
package boot_seq_pkg;

    // Sequencer phases: never-started, reset held, startup count, running
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_HELD = 2'd1,
        ST_BOOT = 2'd2,
        ST_RUN  = 2'd3
    } boot_state_t;

endpackage

// File: rtl/boot_sync.sv
// Multi-bit, multi-stage synchronizer for asynchronous level inputs.
// Each bit has its own independent flop chain.
// Assumes: STAGES >= 2, and each bit is an independent level (no bus coherency).
module boot_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            // Shift the raw input through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d[b]};
            end

            assign q[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/boot_phase_fsm.sv
// Phase controller. It measures the synchronized reset width, holds the core,
// runs the startup count, issues the fetch pulse and opens the interrupt window.
// Assumes: rst_sync is already in the clk domain; 2 <= NMI_GAP <= STARTUP_CYCLES.
module boot_phase_fsm
    import boot_seq_pkg::*;
#(
    parameter int MIN_HIGH       = 4,
    parameter int STARTUP_CYCLES = 7,
    parameter int NMI_GAP        = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_sync,
    output logic core_hold,
    output logic fetch_start,
    output logic nmi_allowed,
    output logic reset_too_short
);

    localparam int HI_W   = $clog2(MIN_HIGH + 2);
    localparam int BOOT_W = (STARTUP_CYCLES > 1) ? $clog2(STARTUP_CYCLES) : 1;
    localparam logic [HI_W-1:0]   HI_LIMIT  = HI_W'(MIN_HIGH);
    localparam logic [BOOT_W-1:0] BOOT_LAST = BOOT_W'(STARTUP_CYCLES - 1);
    localparam logic [BOOT_W-1:0] NMI_AT    = BOOT_W'(NMI_GAP - 2);

    boot_state_t       state;
    logic [HI_W-1:0]   hi_cnt;
    logic [BOOT_W-1:0] boot_cnt;
    logic              resume_run;

    // Phase transitions, width measurement and startup counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= ST_WAIT;
            hi_cnt          <= '0;
            boot_cnt        <= '0;
            resume_run      <= 1'b0;
            fetch_start     <= 1'b0;
            nmi_allowed     <= 1'b0;
            reset_too_short <= 1'b0;
        end else begin
            fetch_start <= 1'b0;
            unique case (state)
                ST_WAIT, ST_RUN: begin
                    if (rst_sync) begin
                        state           <= ST_HELD;
                        hi_cnt          <= HI_W'(1);
                        resume_run      <= (state == ST_RUN);
                        reset_too_short <= 1'b0;
                        nmi_allowed     <= 1'b0;
                    end
                end
                ST_HELD: begin
                    if (rst_sync) begin
                        if (hi_cnt <= HI_LIMIT) hi_cnt <= hi_cnt + 1'b1;
                    end else if (hi_cnt > HI_LIMIT) begin
                        state    <= ST_BOOT;
                        boot_cnt <= '0;
                    end else begin
                        reset_too_short <= 1'b1;
                        state           <= resume_run ? ST_RUN : ST_WAIT;
                        nmi_allowed     <= resume_run;
                    end
                end
                ST_BOOT: begin
                    if (rst_sync) begin
                        state           <= ST_HELD;
                        hi_cnt          <= HI_W'(1);
                        resume_run      <= 1'b0;
                        reset_too_short <= 1'b0;
                        nmi_allowed     <= 1'b0;
                    end else begin
                        if (boot_cnt == NMI_AT) nmi_allowed <= 1'b1;
                        if (boot_cnt == BOOT_LAST) begin
                            state       <= ST_RUN;
                            fetch_start <= 1'b1;
                        end else begin
                            boot_cnt <= boot_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_WAIT;
            endcase
        end
    end

    // Core is dormant in every phase except running
    always_comb core_hold = (state != ST_RUN);

    AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |=> !fetch_start); // R4
    AST_FETCH_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |-> !core_hold); // R4
    AST_HOLD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_sync |=> (core_hold && !fetch_start)); // R2
    AST_SHORT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        reset_too_short |-> !fetch_start); // R3
    AST_WINDOW_SHUT_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_sync |=> !nmi_allowed); // R7

endmodule

// File: rtl/boot_nmi_gate.sv
// Interrupt gate. It detects rising edges on the synchronized interrupt
// request, delivers them while the window is open, and parks early ones.
// Assumes: nmi_sync is already in the clk domain.
module boot_nmi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_sync,
    input  logic allowed,
    output logic nmi_take,
    output logic nmi_pending
);

    logic nmi_prev;
    logic nmi_edge;

    // Remember the previous level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_prev <= 1'b0;
        else        nmi_prev <= nmi_sync;
    end

    always_comb nmi_edge = nmi_sync && !nmi_prev;

    // Deliver or park each detected edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_take    <= 1'b0;
            nmi_pending <= 1'b0;
        end else begin
            nmi_take    <= allowed && (nmi_edge || nmi_pending);
            nmi_pending <= !allowed && (nmi_pending || nmi_edge);
        end
    end

    AST_TAKE_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_take |-> $past(allowed)); // R8
    AST_PENDING_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pending && allowed) |=> (nmi_take && !nmi_pending)); // R9
    AST_NO_PARK_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        allowed |=> !nmi_pending); // R9

endmodule

// File: rtl/boot_sequencer.sv
// Top level of the reset and startup sequencer. It synchronizes the reset and
// interrupt pins, sequences core startup and gates the interrupt.
// Assumes: rst_n is synchronous to clk; reset_pin and nmi_pin are asynchronous.
module boot_sequencer #(
    parameter int          ADDR_W         = 20,
    parameter int          SYNC_STAGES    = 2,
    parameter int          MIN_HIGH       = 4,
    parameter int          STARTUP_CYCLES = 7,
    parameter int          NMI_GAP        = 2,
    parameter logic [19:0] START_ADDR     = 20'hFFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_pin,
    input  logic              nmi_pin,
    output logic              core_hold,
    output logic              fetch_start,
    output logic [ADDR_W-1:0] reset_vector,
    output logic              nmi_allowed,
    output logic              nmi_pending,
    output logic              nmi_take,
    output logic              reset_too_short
);

    logic [1:0] pins_sync;

    boot_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({nmi_pin, reset_pin}),
        .q     (pins_sync)
    );

    boot_phase_fsm #(
        .MIN_HIGH       (MIN_HIGH),
        .STARTUP_CYCLES (STARTUP_CYCLES),
        .NMI_GAP        (NMI_GAP)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .rst_sync        (pins_sync[0]),
        .core_hold       (core_hold),
        .fetch_start     (fetch_start),
        .nmi_allowed     (nmi_allowed),
        .reset_too_short (reset_too_short)
    );

    boot_nmi_gate u_nmi (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_sync    (pins_sync[1]),
        .allowed     (nmi_allowed),
        .nmi_take    (nmi_take),
        .nmi_pending (nmi_pending)
    );

    // Fixed power-on fetch address
    always_comb reset_vector = START_ADDR[ADDR_W-1:0];

    AST_VECTOR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        reset_vector == 20'hFFFF0); // R5

endmodule

// File: tb/boot_sequencer_bench.sv
module boot_sequencer_bench;

    localparam int MIN_HIGH = 4;
    localparam int FETCH_AT = 10; // edges after pin fall; a pulse of w edges puts fetch at w+10

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_pin = 1'b0;
    logic nmi_pin = 1'b0;
    logic core_hold, fetch_start, nmi_allowed, nmi_pending, nmi_take, reset_too_short;
    logic [19:0] reset_vector;

    int  tests = 0;
    int  fails = 0;
    bit  running = 1'b0;
    bit  prev_short = 1'b0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    boot_sequencer u_boot_sequencer (
        .clk(clk), .rst_n(rst_n), .reset_pin(reset_pin), .nmi_pin(nmi_pin),
        .core_hold(core_hold), .fetch_start(fetch_start), .reset_vector(reset_vector),
        .nmi_allowed(nmi_allowed), .nmi_pending(nmi_pending), .nmi_take(nmi_take),
        .reset_too_short(reset_too_short)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected outputs after edge i of a pulse w edges wide (pin high before edge 1)
    function automatic bit exp_hold(int i, int w, bit run0);
        if (i < 3) return !run0;
        if (w > MIN_HIGH) return (i < w + FETCH_AT);
        if (i <= w + 2) return 1'b1;
        return !run0;
    endfunction

    function automatic bit exp_fetch(int i, int w);
        return (w > MIN_HIGH) && (i == w + FETCH_AT);
    endfunction

    function automatic bit exp_allowed(int i, int w, bit run0);
        if (i < 3) return run0;
        if (w > MIN_HIGH) return (i >= w + 4);
        if (i <= w + 2) return 1'b0;
        return run0;
    endfunction

    function automatic bit exp_short(int i, int w, bit short0);
        if (i < 3) return short0;
        if (i <= w + 2) return 1'b0;
        return (w <= MIN_HIGH);
    endfunction

    task automatic do_pulse(int w);
        string tag;
        tag = (w > MIN_HIGH) ? "R4" : "R3";
        reset_pin = 1'b1;
        for (int i = 1; i <= w + 12; i++) begin
            tick();
            chk((i >= 3 && i <= w + 2) ? "R2" : tag, $sformatf("hold w=%0d i=%0d", w, i),
                core_hold, exp_hold(i, w, running));
            chk(tag, $sformatf("fetch w=%0d i=%0d", w, i), fetch_start, exp_fetch(i, w));
            chk("R7", $sformatf("allowed w=%0d i=%0d", w, i), nmi_allowed, exp_allowed(i, w, running));
            chk("R3", $sformatf("short w=%0d i=%0d", w, i), reset_too_short, exp_short(i, w, prev_short));
            if (i == w) reset_pin = 1'b0;
        end
        if (w > MIN_HIGH) running = 1'b1;
        prev_short = (w <= MIN_HIGH);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        // R1: power-on reset values
        repeat (3) tick();
        chk("R1", "hold in reset", core_hold, 1);
        chk("R1", "fetch in reset", fetch_start, 0);
        chk("R1", "allowed in reset", nmi_allowed, 0);
        chk("R1", "pending in reset", nmi_pending, 0);
        chk("R1", "take in reset", nmi_take, 0);
        chk("R1", "short in reset", reset_too_short, 0);
        chk("R5", "vector", reset_vector, 20'hFFFF0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R1", "hold with no pulse", core_hold, 1);
            chk("R1", "no fetch with no pulse", fetch_start, 0);
        end

        // R3 boundary from a held core, then first valid start
        do_pulse(4);
        do_pulse(5);
        chk("R5", "vector after start", reset_vector, 20'hFFFF0);
        // R3: short pulses from a running core resume without fetch
        do_pulse(4);
        do_pulse(1);

        // R8: direct interrupt delivery while running
        nmi_pin = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            tick();
            chk("R8", $sformatf("take i=%0d", i), nmi_take, (i == 3));
            chk("R8", $sformatf("no pending i=%0d", i), nmi_pending, 0);
        end
        nmi_pin = 1'b0;
        repeat (3) tick();

        // R9: an interrupt edge inside the blocked window is parked and delivered once
        reset_pin = 1'b1;
        for (int i = 1; i <= 18; i++) begin
            tick();
            if (i == 6)  chk("R9", "pending before edge", nmi_pending, 0);
            if (i == 7)  begin chk("R9", "parked", nmi_pending, 1); chk("R9", "not taken", nmi_take, 0); end
            if (i == 10) begin chk("R7", "window open", nmi_allowed, 1); chk("R9", "still parked", nmi_pending, 1); chk("R9", "not yet taken", nmi_take, 0); end
            if (i == 11) begin chk("R9", "delivered", nmi_take, 1); chk("R9", "pending cleared", nmi_pending, 0); end
            if (i == 12) chk("R9", "single delivery", nmi_take, 0);
            if (i == 16) chk("R4", "fetch after nmi pulse", fetch_start, 1);
            if (i == 4) nmi_pin = 1'b1;
            if (i == 6) reset_pin = 1'b0;
        end
        nmi_pin = 1'b0;
        repeat (3) tick();
        chk("R8", "no late take", nmi_take, 0);

        // R6: a short pulse inside the startup count aborts it and leaves the core held
        reset_pin = 1'b1;
        for (int i = 1; i <= 9; i++) begin
            tick();
            if (i == 6) reset_pin = 1'b0;
        end
        chk("R6", "in startup hold", core_hold, 1);
        reset_pin = 1'b1;
        for (int i = 1; i <= 16; i++) begin
            tick();
            chk("R6", $sformatf("held after abort i=%0d", i), core_hold, 1);
            chk("R6", $sformatf("no fetch after abort i=%0d", i), fetch_start, 0);
            if (i == 2) reset_pin = 1'b0;
        end
        chk("R6", "abort flagged short", reset_too_short, 1);
        running = 1'b0;
        prev_short = 1'b1;
        do_pulse(7);

        // Random pulse widths and gaps against the bench timeline
        for (int n = 0; n < 30; n++) begin
            int w;
            int gap;
            w = 1 + int'($urandom % 9);
            gap = int'($urandom % 4);
            for (int g = 0; g < gap; g++) begin
                tick();
                chk("R4", "idle hold", core_hold, !running);
                chk("R4", "idle fetch", fetch_start, 0);
            end
            do_pulse(w);
        end
        chk("R5", "vector at end", reset_vector, 20'hFFFF0);
        finish_run();
    end

endmodule